// File: doc/BRIEF.md
# Set-Associative Instruction Address Translator

This block maps instruction-fetch virtual addresses to physical addresses using a table of paired entries. Each entry pair has a match word, which holds a valid flag, a two-bit usage counter and a virtual page tag. It also has a translate word, which holds a physical page number, a cache-inhibit flag and two execute permissions, one for supervisor mode and one for user mode. The table is organised as `NWAYS` ways (1 to 4) by `NSETS` sets (a power of two, at most 128). The page is `2**PAGE_LOG2` bytes, 8192 by default. Software fills the table through a one-word write port and can read any match word back.

A fetch request is answered one clock later with registered outputs: hit or miss, the physical address, a cache-inhibit bit and a page-fault bit. There is no hardware refill. A miss only raises the miss flag, and software is expected to load an entry and retry. When translation is switched off, or the unit is strapped as absent, addresses pass straight through, and cache-inhibit follows the top address bit. A separate combinational peek port runs the same lookup for debug use and changes no state. A constant configuration word reports the geometry.

Top module: `itlb_xlate`

## Requirements
- R1: With `xlate_en_i` low or `present_i` low, a request returns `pa_o` equal to the virtual address, `ci_o` equal to address bit 31, and `hit_o`, `miss_o` and `fault_o` all low.
- R2: The set is chosen by virtual address bits `[PAGE_LOG2 +: log2(NSETS)]`. An entry held in a different set never matches, even if its tag agrees.
- R3: A way hits only when match-word bit 0 (valid) is set and match-word bits `[31:PAGE_LOG2+log2(NSETS)]` equal the same bits of the address.
- R4: On a hit, `pa_o` is translate-word bits `[31:PAGE_LOG2]` joined with the address's page-offset bits, and `ci_o` is translate-word bit 0.
- R5: On a hit, `fault_o` is raised when the requester is supervisor (`super_i`=1) and translate bit 1 is clear, or when it is user (`super_i`=0) and translate bit 2 is clear.
- R6: The usage counter is match-word bits [7:6]. On a translated hit, every other way of that set with a nonzero counter drops by one, and the hit way's counter becomes 3.
- R7: A translated miss raises `miss_o`, returns `pa_o` = 0 with `fault_o` low, refills nothing and leaves all counters unchanged.
- R8: When several ways of a set match, the lowest-numbered way supplies the translation.
- R9: `cfg_o` bits [2:0] hold log2(NSETS), bits [4:3] hold NWAYS−1, and the other bits are zero.
- R10: `pk_pa_o` gives the translated address on a permitted hit, 0 on a miss or a permission failure, and the virtual address when translation is off. The peek port never changes counters or the response outputs.
- R11: After reset every match word reads 0 (invalid, counter 0), and `rsp_valid_o`, `hit_o`, `miss_o` and `fault_o` are low.
- R12: Outputs are registered. `rsp_valid_o` is high exactly in the cycle after `f_req_i` was sampled high, and the response fields belong to that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlate_en_i | input | 1 | Translation enable from the mode register |
| present_i | input | 1 | Unit-present strap |
| super_i | input | 1 | 1 = supervisor, 0 = user requester |
| f_req_i | input | 1 | Fetch lookup request |
| f_va_i | input | 32 | Fetch virtual address |
| wr_en_i | input | 1 | Table write strobe |
| wr_tr_i | input | 1 | 0 = write match word, 1 = write translate word |
| wr_way_i | input | WAY_W | Way written |
| wr_set_i | input | IDX_W | Set written |
| wr_data_i | input | 32 | Word written |
| rd_way_i | input | WAY_W | Way of match word read back |
| rd_set_i | input | IDX_W | Set of match word read back |
| rd_match_o | output | 32 | Match word read back (combinational) |
| pk_va_i | input | 32 | Peek virtual address |
| pk_pa_o | output | 32 | Peek physical address (combinational) |
| rsp_valid_o | output | 1 | Response valid |
| hit_o | output | 1 | Translated hit |
| miss_o | output | 1 | Translated miss |
| fault_o | output | 1 | Execute-permission fault |
| ci_o | output | 1 | Cache inhibit |
| pa_o | output | 32 | Physical address |
| cfg_o | output | 8 | Geometry word |

## Verification
The bench builds the translator with four sets and two ways on the default 8192-byte page. Four sets put two index bits between the page offset and the tag, so an address can be steered to the wrong set while its tag still agrees, and a tag can be made to differ only in the bit just above the index. Two ways allow a genuine double match to test lowest-way priority. They also let one way's counter be observed decaying while its neighbour is reloaded, which the default single-way build cannot show.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
   localparam int ADDR_W    = 32;
   localparam int VALID_BIT = 0;
   localparam int CNT_LSB   = 6;
   localparam int CNT_W     = 2;
   localparam int CI_BIT    = 0;
   localparam int SXE_BIT   = 1;
   localparam int UXE_BIT   = 2;
   localparam int CFG_W     = 8;

   // Usage counter step: a hit way saturates, others decay toward zero.
   function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c,
                                                 input logic is_hit);
      if (is_hit)
         return {CNT_W{1'b1}};
      else if (c != '0)
         return c - 1'b1;
      else
         return c;
   endfunction
endpackage

// File: rtl/itlb_way_bank.sv
module itlb_way_bank
   import itlb_pkg::*;
#(
   parameter int NSETS = 1,
   parameter int IDX_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_mr_en,
   input  logic              wr_tr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              cnt_en,
   input  logic              cnt_hit,
   input  logic [IDX_W-1:0]  lk_idx,
   input  logic [IDX_W-1:0]  pk_idx,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] lk_mr,
   output logic [ADDR_W-1:0] lk_tr,
   output logic [ADDR_W-1:0] pk_mr,
   output logic [ADDR_W-1:0] pk_tr,
   output logic [ADDR_W-1:0] rd_mr
);
   logic [ADDR_W-1:0] mr_q [NSETS];
   logic [ADDR_W-1:0] tr_q [NSETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NSETS; s++) begin
            mr_q[s] <= '0;
            tr_q[s] <= '0;
         end
      end else begin
         for (int s = 0; s < NSETS; s++) begin
            if (wr_mr_en && wr_idx == IDX_W'(s))
               mr_q[s] <= wr_data;
            else if (cnt_en && lk_idx == IDX_W'(s))
               mr_q[s][CNT_LSB +: CNT_W] <= cnt_next(mr_q[s][CNT_LSB +: CNT_W], cnt_hit);
            if (wr_tr_en && wr_idx == IDX_W'(s))
               tr_q[s] <= wr_data;
         end
      end
   end

   assign lk_mr = mr_q[lk_idx];
   assign lk_tr = tr_q[lk_idx];
   assign pk_mr = mr_q[pk_idx];
   assign pk_tr = tr_q[pk_idx];
   assign rd_mr = mr_q[rd_idx];
endmodule

// File: rtl/itlb_way_select.sv
module itlb_way_select
   import itlb_pkg::*;
#(
   parameter int NWAYS     = 1,
   parameter int WAY_W     = 1,
   parameter int TAG_LSB   = 13
) (
   input  logic [NWAYS-1:0][ADDR_W-1:0] mr,
   input  logic [ADDR_W-1:0]            va,
   output logic                         any,
   output logic [WAY_W-1:0]             way
);
   localparam logic [ADDR_W-1:0] TAG_MASK = ~((ADDR_W'(1) << TAG_LSB) - 1'b1);

   logic [NWAYS-1:0] match;

   for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
      assign match[w] = mr[w][VALID_BIT] && ((mr[w] & TAG_MASK) == (va & TAG_MASK));
   end

   always_comb begin
      way = '0;
      for (int w = NWAYS - 1; w >= 0; w--)
         if (match[w]) way = WAY_W'(w);
   end

   assign any = |match;
endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
   import itlb_pkg::*;
#(
   parameter int NSETS     = 1,
   parameter int NWAYS     = 1,
   parameter int PAGE_LOG2 = 13,
   localparam int SET_W    = $clog2(NSETS),
   localparam int IDX_W    = (SET_W == 0) ? 1 : SET_W,
   localparam int WAY_W    = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xlate_en_i,
   input  logic              present_i,
   input  logic              super_i,
   input  logic              f_req_i,
   input  logic [31:0]       f_va_i,
   input  logic              wr_en_i,
   input  logic              wr_tr_i,
   input  logic [WAY_W-1:0]  wr_way_i,
   input  logic [IDX_W-1:0]  wr_set_i,
   input  logic [31:0]       wr_data_i,
   input  logic [WAY_W-1:0]  rd_way_i,
   input  logic [IDX_W-1:0]  rd_set_i,
   output logic [31:0]       rd_match_o,
   input  logic [31:0]       pk_va_i,
   output logic [31:0]       pk_pa_o,
   output logic              rsp_valid_o,
   output logic              hit_o,
   output logic              miss_o,
   output logic              fault_o,
   output logic              ci_o,
   output logic [31:0]       pa_o,
   output logic [7:0]        cfg_o
);
   localparam logic [IDX_W-1:0]  SET_MASK = IDX_W'(NSETS - 1);
   localparam logic [ADDR_W-1:0] OFF_MASK = (ADDR_W'(1) << PAGE_LOG2) - 1'b1;

   if (NWAYS < 1 || NWAYS > 4) begin : g_bad_ways
      $error("itlb_xlate: NWAYS must be 1..4");
   end
   if (NSETS < 1 || NSETS > 128 || (NSETS & (NSETS - 1)) != 0) begin : g_bad_sets
      $error("itlb_xlate: NSETS must be a power of two up to 128");
   end
   if (PAGE_LOG2 < CNT_LSB + CNT_W || PAGE_LOG2 + SET_W >= ADDR_W) begin : g_bad_page
      $error("itlb_xlate: PAGE_LOG2 out of range");
   end

   logic active;
   assign active = xlate_en_i && present_i;

   logic [IDX_W-1:0] lk_idx, pk_idx;
   assign lk_idx = f_va_i[PAGE_LOG2 +: IDX_W] & SET_MASK;
   assign pk_idx = pk_va_i[PAGE_LOG2 +: IDX_W] & SET_MASK;

   logic [NWAYS-1:0][ADDR_W-1:0] lk_mr, lk_tr, pk_mr, pk_tr, rd_mr;
   logic             lk_any, pk_any;
   logic [WAY_W-1:0] lk_way, pk_way;
   logic             cnt_en;

   assign cnt_en = f_req_i && active && lk_any;

   for (genvar w = 0; w < NWAYS; w++) begin : g_way
      itlb_way_bank #(.NSETS(NSETS), .IDX_W(IDX_W)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_mr_en (wr_en_i && !wr_tr_i && wr_way_i == WAY_W'(w)),
         .wr_tr_en (wr_en_i &&  wr_tr_i && wr_way_i == WAY_W'(w)),
         .wr_idx   (wr_set_i & SET_MASK),
         .wr_data  (wr_data_i),
         .cnt_en   (cnt_en),
         .cnt_hit  (lk_way == WAY_W'(w)),
         .lk_idx   (lk_idx),
         .pk_idx   (pk_idx),
         .rd_idx   (rd_set_i & SET_MASK),
         .lk_mr    (lk_mr[w]),
         .lk_tr    (lk_tr[w]),
         .pk_mr    (pk_mr[w]),
         .pk_tr    (pk_tr[w]),
         .rd_mr    (rd_mr[w])
      );
   end

   itlb_way_select #(.NWAYS(NWAYS), .WAY_W(WAY_W), .TAG_LSB(PAGE_LOG2 + SET_W)) u_sel_lk (
      .mr(lk_mr), .va(f_va_i), .any(lk_any), .way(lk_way)
   );
   itlb_way_select #(.NWAYS(NWAYS), .WAY_W(WAY_W), .TAG_LSB(PAGE_LOG2 + SET_W)) u_sel_pk (
      .mr(pk_mr), .va(pk_va_i), .any(pk_any), .way(pk_way)
   );

   // Translation of the fetch port.
   logic [ADDR_W-1:0] lk_te, pk_te, lk_pa;
   logic              lk_perm, pk_perm;
   assign lk_te   = lk_tr[lk_way];
   assign pk_te   = pk_tr[pk_way];
   assign lk_pa   = (lk_te & ~OFF_MASK) | (f_va_i & OFF_MASK);
   assign lk_perm = super_i ? lk_te[SXE_BIT] : lk_te[UXE_BIT];
   assign pk_perm = super_i ? pk_te[SXE_BIT] : pk_te[UXE_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_o <= 1'b0;
         hit_o       <= 1'b0;
         miss_o      <= 1'b0;
         fault_o     <= 1'b0;
         ci_o        <= 1'b0;
         pa_o        <= '0;
      end else begin
         rsp_valid_o <= f_req_i;
         hit_o       <= 1'b0;
         miss_o      <= 1'b0;
         fault_o     <= 1'b0;
         if (f_req_i) begin
            if (!active) begin
               pa_o <= f_va_i;
               ci_o <= f_va_i[ADDR_W-1];
            end else if (lk_any) begin
               hit_o   <= 1'b1;
               fault_o <= !lk_perm;
               pa_o    <= lk_pa;
               ci_o    <= lk_te[CI_BIT];
            end else begin
               miss_o <= 1'b1;
               pa_o   <= '0;
               ci_o   <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      if (!active)
         pk_pa_o = pk_va_i;
      else if (pk_any && pk_perm)
         pk_pa_o = (pk_te & ~OFF_MASK) | (pk_va_i & OFF_MASK);
      else
         pk_pa_o = '0;
   end

   assign rd_match_o = (int'(rd_way_i) < NWAYS) ? rd_mr[rd_way_i] : '0;
   assign cfg_o      = {3'b000, 2'(NWAYS - 1), 3'(SET_W)};
endmodule

// File: rtl/itlb_xlate_chk.sv
module itlb_xlate_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        xlate_en_i,
   input logic        present_i,
   input logic        f_req_i,
   input logic [31:0] f_va_i,
   input logic        rsp_valid_o,
   input logic        hit_o,
   input logic        miss_o,
   input logic        fault_o,
   input logic        ci_o,
   input logic [31:0] pa_o,
   input logic [7:0]  cfg_o
);
   p_hit_miss_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_o && miss_o));

   p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      miss_o |-> (pa_o == 32'h0 && !fault_o && !ci_o));

   p_fault_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> hit_o);

   p_resp_timing_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (rsp_valid_o == $past(f_req_i)));

   p_flags_need_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o || miss_o) |-> rsp_valid_o);

   p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(f_req_i) && !($past(xlate_en_i) && $past(present_i)))
      |-> (pa_o == $past(f_va_i) && ci_o == $past(f_va_i[31]) && !hit_o && !miss_o));

   p_cfg_const_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(cfg_o));
endmodule

bind itlb_xlate itlb_xlate_chk u_chk (
   .clk(clk), .rst_n(rst_n), .xlate_en_i(xlate_en_i), .present_i(present_i),
   .f_req_i(f_req_i), .f_va_i(f_va_i), .rsp_valid_o(rsp_valid_o),
   .hit_o(hit_o), .miss_o(miss_o), .fault_o(fault_o), .ci_o(ci_o),
   .pa_o(pa_o), .cfg_o(cfg_o)
);

// File: tb/itlb_xlate_tb_top.sv
module itlb_xlate_tb_top;
   localparam int NSETS = 4;
   localparam int NWAYS = 2;
   localparam int IDX_W = 2;
   localparam int WAY_W = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic xlate_en_i = 1'b1, present_i = 1'b1, super_i = 1'b1;
   logic f_req_i = 1'b0;
   logic [31:0] f_va_i = '0;
   logic wr_en_i = 1'b0, wr_tr_i = 1'b0;
   logic [WAY_W-1:0] wr_way_i = '0, rd_way_i = '0;
   logic [IDX_W-1:0] wr_set_i = '0, rd_set_i = '0;
   logic [31:0] wr_data_i = '0, pk_va_i = '0;
   logic [31:0] rd_match_o, pk_pa_o, pa_o;
   logic rsp_valid_o, hit_o, miss_o, fault_o, ci_o;
   logic [7:0] cfg_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   itlb_xlate #(.NSETS(NSETS), .NWAYS(NWAYS), .PAGE_LOG2(13)) dut_i (
      .clk(clk), .rst_n(rst_n), .xlate_en_i(xlate_en_i), .present_i(present_i),
      .super_i(super_i), .f_req_i(f_req_i), .f_va_i(f_va_i),
      .wr_en_i(wr_en_i), .wr_tr_i(wr_tr_i), .wr_way_i(wr_way_i), .wr_set_i(wr_set_i),
      .wr_data_i(wr_data_i), .rd_way_i(rd_way_i), .rd_set_i(rd_set_i),
      .rd_match_o(rd_match_o), .pk_va_i(pk_va_i), .pk_pa_o(pk_pa_o),
      .rsp_valid_o(rsp_valid_o), .hit_o(hit_o), .miss_o(miss_o), .fault_o(fault_o),
      .ci_o(ci_o), .pa_o(pa_o), .cfg_o(cfg_o)
   );

   typedef struct packed {
      logic [31:0] va;
      logic        sup;
      logic        hit;
      logic        miss;
      logic        fault;
      logic        ci;
      logic [31:0] pa;
   } vec_t;

   // R2/R3/R4/R5/R7 vectors against the table loaded below.
   localparam vec_t VECS [6] = '{
      '{32'h0000_2ABC, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h4000_0ABC}, // R4 hit sup
      '{32'h0000_2ABC, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h4000_0ABC}, // R5 user no exec
      '{32'h0001_5FF0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h8000_3FF0}, // R4 way1 hit
      '{32'h0000_6010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000}, // R3 invalid entry
      '{32'h0000_A000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000}, // R3 tag bit 15 differs
      '{32'h0001_0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000}  // R2 wrong set
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic tr, input int way, input int set, input logic [31:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_tr_i = tr; wr_way_i = WAY_W'(way); wr_set_i = IDX_W'(set); wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic lookup(input logic [31:0] va, input logic sup);
      @(negedge clk);
      f_req_i = 1'b1; f_va_i = va; super_i = sup;
      @(negedge clk);
      f_req_i = 1'b0;
   endtask

   function automatic logic [31:0] rd(input int way, input int set);
      rd_way_i = WAY_W'(way); rd_set_i = IDX_W'(set);
      return 32'h0;
   endfunction

   task automatic rdchk(input string req, input int way, input int set, input logic [31:0] exp);
      logic [31:0] dummy;
      dummy = rd(way, set);
      #0.5;
      check(req, rd_match_o, exp ^ dummy);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11 rsp_valid", {31'b0, rsp_valid_o}, 32'h0);
      check("R11 hit/miss/fault", {29'b0, hit_o, miss_o, fault_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rdchk("R11 match word cleared", 1, 2, 32'h0);
      // R9
      check("R9 cfg", {24'b0, cfg_o}, 32'h0000_000A);

      // Load table.
      wr(1'b0, 0, 1, 32'h0000_0001);
      wr(1'b1, 0, 1, 32'h4000_0003);
      wr(1'b0, 1, 2, 32'h0001_0001);
      wr(1'b1, 1, 2, 32'h8000_2006);
      wr(1'b0, 0, 3, 32'h0000_0000);
      wr(1'b1, 0, 3, 32'h7000_0007);

      foreach (VECS[i]) begin
         lookup(VECS[i].va, VECS[i].sup);
         check("R12 rsp_valid", {31'b0, rsp_valid_o}, 32'h1);
         check("R3 hit", {31'b0, hit_o}, {31'b0, VECS[i].hit});
         check("R7 miss", {31'b0, miss_o}, {31'b0, VECS[i].miss});
         check("R5 fault", {31'b0, fault_o}, {31'b0, VECS[i].fault});
         check("R4 ci", {31'b0, ci_o}, {31'b0, VECS[i].ci});
         check("R4 pa", pa_o, VECS[i].pa);
      end
      @(negedge clk);
      check("R12 rsp_valid drops", {31'b0, rsp_valid_o}, 32'h0);

      // R6: counter behaviour in set 2.
      rdchk("R6 way1 after hit", 1, 2, 32'h0001_00C1);
      wr(1'b0, 0, 2, 32'h0002_0081);
      lookup(32'h0001_4000, 1'b1);
      rdchk("R6 other way decays", 0, 2, 32'h0002_0041);
      rdchk("R6 hit way reload", 1, 2, 32'h0001_00C1);
      lookup(32'h0002_4000, 1'b1);
      check("R5 sup fault no SXE", {30'b0, hit_o, fault_o}, 32'h3);
      rdchk("R6 way0 reload", 0, 2, 32'h0002_00C1);
      rdchk("R6 way1 decays", 1, 2, 32'h0001_0081);
      lookup(32'h0003_4000, 1'b1);
      check("R7 miss set2", {31'b0, miss_o}, 32'h1);
      rdchk("R7 counters kept way0", 0, 2, 32'h0002_00C1);
      rdchk("R7 counters kept way1", 1, 2, 32'h0001_0081);

      // R8: double match in set 3.
      wr(1'b0, 1, 3, 32'h0000_0001);
      wr(1'b1, 1, 3, 32'h1000_0006);
      wr(1'b0, 0, 3, 32'h0000_0001);
      wr(1'b1, 0, 3, 32'h2000_0006);
      lookup(32'h0000_6004, 1'b0);
      check("R8 lowest way", pa_o, 32'h2000_0004);
      check("R8 no fault", {31'b0, fault_o}, 32'h0);

      // R10: peek port, no side effects.
      @(negedge clk);
      super_i = 1'b0; pk_va_i = 32'h0000_2ABC;
      #0.5 check("R10 peek perm fail", pk_pa_o, 32'h0);
      super_i = 1'b1;
      #0.5 check("R10 peek hit", pk_pa_o, 32'h4000_0ABC);
      pk_va_i = 32'h0003_4000;
      #0.5 check("R10 peek miss", pk_pa_o, 32'h0);
      pk_va_i = 32'h0001_4000;
      repeat (2) @(negedge clk);
      check("R10 no response", {29'b0, rsp_valid_o, hit_o, miss_o}, 32'h0);
      rdchk("R10 counters untouched", 1, 2, 32'h0001_0081);
      xlate_en_i = 1'b0; pk_va_i = 32'h9000_1234;
      #0.5 check("R10 peek passthrough", pk_pa_o, 32'h9000_1234);

      // R1: passthrough.
      lookup(32'h8000_1234, 1'b1);
      check("R1 pa", pa_o, 32'h8000_1234);
      check("R1 ci high", {29'b0, ci_o, hit_o, miss_o}, 32'h4);
      lookup(32'h7FFF_FFFC, 1'b1);
      check("R1 ci low", {31'b0, ci_o}, 32'h0);
      xlate_en_i = 1'b1; present_i = 1'b0;
      lookup(32'h8000_0000, 1'b0);
      check("R1 absent pa", pa_o, 32'h8000_0000);
      check("R1 absent ci", {29'b0, ci_o, hit_o, miss_o}, 32'h4);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule